// File: doc/BRIEF.md
# Parallel Page-Programming Port for On-Chip Flash

This block sits on the target side of a parallel programming link. An external programmer drives a 2-bit mode code, a byte-select line, an 8-bit data bus and three strobes. A load strobe captures the bus as a command, an address byte or a data byte, depending on the mode code and byte-select. A latch strobe copies the staged 16-bit data word into a page buffer. A falling pulse on the write line starts the stored command against a behavioural flash array, which is either a chip erase or a page program.

All three strobes are treated as asynchronous pins. Each passes through a synchronizer and an edge detector in the system clock domain. A ready output is low while an operation runs. Any strobe that arrives during that time is dropped. A combinational read port exposes the array contents so that programmed data can be checked.

The word index inside a page comes from the low address bits. The page number comes from the bits above them. With the default 128-word page, bit 7 of the low address byte is already the least significant page bit.

Top module: `pflash_prog_if`

## Requirements
- R1: With mode code 2'b10, a rising load strobe stores the data bus as the command. Code 8'h80 means chip erase and code 8'h10 means page program.
- R2: With mode code 2'b00, a rising load strobe stores an address byte. It goes to the low byte when byte-select is 0 and to the high byte when byte-select is 1.
- R3: With mode code 2'b01, a rising load strobe stores a data byte. It goes to the low byte when byte-select is 0 and to the high byte when byte-select is 1.
- R4: With mode code 2'b11, a load strobe changes neither the command nor the address.
- R5: A rising latch strobe writes {high data byte, low data byte} into the page buffer at the word index given by the low log2(PAGE_WORDS) address bits.
- R6: A page program copies every word of the page buffer into the page addressed by the address bits above the word index. These bits include the upper bits of the low address byte.
- R7: A chip erase sets every array word to 16'hFFFF.
- R8: A write pulse that starts an operation holds ready low for exactly BUSY_CYC clock cycles. The array keeps its contents until the last of those cycles.
- R9: Load, latch and write strobes that arrive while ready is low have no effect.
- R10: A write pulse while any other command is stored leaves ready high and the array unchanged.
- R11: After reset, ready is high and every array word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Load target: 00 address, 01 data, 10 command, 11 none |
| byte_hi | input | 1 | Selects the high byte for address or data loads |
| data_in | input | 8 | Programming data bus |
| load_stb | input | 1 | Load strobe, active on its rising edge |
| latch_stb | input | 1 | Page-buffer latch strobe, active on its rising edge |
| wr_n | input | 1 | Write line, starts the command on its falling edge |
| rd_addr | input | MEM_AW | Array word address for read-back |
| rd_data | output | 16 | Array word at rd_addr |
| rdy | output | 1 | High when idle, low while an operation runs |

## Verification
On every cycle, the assertions check three things. Registers and the in-flight operation stay frozen while busy. Mode 11 loads leave command and address alone, and unknown commands never raise busy. Busy cannot drop before its count expires, the array changes only in the commit cycle, and an erase leaves the first and last words at all ones. The bench scenarios show the rest. These are the mapping of the word index and the low-byte page bit onto real array locations, the full contents of each programmed page and of the rest of the array, and the exact width of the ready-low window as seen at the pins.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'b00,
    SEL_DATA = 2'b01,
    SEL_CMD  = 2'b10,
    SEL_NONE = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2
  } op_e;

  localparam logic [7:0] OPC_ERASE = 8'h80;
  localparam logic [7:0] OPC_PROG  = 8'h10;

endpackage

// File: rtl/pflash_edge_det.sv
module pflash_edge_det #(
  parameter bit IDLE_LVL = 1'b0,
  parameter bit RISING   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pulse
);

  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {3{IDLE_LVL}};
    else        sh_q <= sh_d;
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = sh_q[1] & ~sh_q[2];
    end else begin : g_fall
      assign pulse = ~sh_q[1] & sh_q[2];
    end
  endgenerate

endmodule

// File: rtl/pflash_load_regs.sv
module pflash_load_regs
  import pflash_pkg::*;
#(
  parameter int PAGE_WORDS = 128,
  parameter int PAGES      = 8,
  localparam int WIDX_W    = $clog2(PAGE_WORDS),
  localparam int PG_W      = $clog2(PAGES),
  localparam int MEM_AW    = WIDX_W + PG_W,
  localparam int HI_W      = MEM_AW - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              load_ev,
  input  logic              latch_ev,
  input  logic [1:0]        sel,
  input  logic              byte_hi,
  input  logic [7:0]        din,
  output logic [7:0]        cmd_q,
  output logic [PG_W-1:0]   pg_o,
  output logic [15:0]       page_buf [PAGE_WORDS]
);

  logic [7:0]      alo_q, alo_d;
  logic [HI_W-1:0] ahi_q, ahi_d;
  logic [7:0]      dlo_q, dlo_d;
  logic [7:0]      dhi_q, dhi_d;
  logic [7:0]      cmd_d;
  logic            ld_en;
  logic            buf_we;
  logic [WIDX_W-1:0] widx;
  logic [MEM_AW-1:0] addr_full;

  assign ld_en     = load_ev & ~busy;
  assign buf_we    = latch_ev & ~busy;
  assign addr_full = {ahi_q, alo_q};
  assign widx      = addr_full[WIDX_W-1:0];
  assign pg_o      = addr_full[MEM_AW-1:WIDX_W];

  always_comb begin
    cmd_d = cmd_q;
    alo_d = alo_q;
    ahi_d = ahi_q;
    dlo_d = dlo_q;
    dhi_d = dhi_q;
    if (ld_en) begin
      case (sel_e'(sel))
        SEL_CMD:  cmd_d = din;
        SEL_ADDR: if (byte_hi) ahi_d = din[HI_W-1:0];
                  else         alo_d = din;
        SEL_DATA: if (byte_hi) dhi_d = din;
                  else         dlo_d = din;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      alo_q <= '0;
      ahi_q <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      alo_q <= alo_d;
      ahi_q <= ahi_d;
      dlo_q <= dlo_d;
      dhi_q <= dhi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < PAGE_WORDS; w++) page_buf[w] <= '1;
    end else if (buf_we) begin
      page_buf[widx] <= {dhi_q, dlo_q};
    end
  end

  p_hold_cmd_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));
  p_hold_addr_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_full));
  p_hold_buf_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(page_buf[widx]));
  p_mode_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && sel == 2'b11) |=> ($stable(cmd_q) && $stable(addr_full)));

endmodule

// File: rtl/pflash_array.sv
module pflash_array
  import pflash_pkg::*;
#(
  parameter int PAGE_WORDS = 128,
  parameter int PAGES      = 8,
  parameter int BUSY_CYC   = 16,
  localparam int WIDX_W    = $clog2(PAGE_WORDS),
  localparam int PG_W      = $clog2(PAGES),
  localparam int MEM_AW    = WIDX_W + PG_W,
  localparam int MEM_WORDS = PAGE_WORDS * PAGES,
  localparam int CNT_W     = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic [7:0]        cmd,
  input  logic [PG_W-1:0]   pg_in,
  input  logic [15:0]       page_buf [PAGE_WORDS],
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              busy
);

  logic [15:0]      mem [MEM_WORDS];
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  op_e              op_q, op_d;
  logic [PG_W-1:0]  pg_q, pg_d;
  logic             cmd_ok;
  logic             start;
  logic             commit;

  assign cmd_ok = (cmd == OPC_ERASE) || (cmd == OPC_PROG);
  assign start  = wr_ev & ~busy_q & cmd_ok;
  assign commit = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    pg_d   = pg_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(BUSY_CYC - 1);
      op_d   = (cmd == OPC_ERASE) ? OP_ERASE : OP_PROG;
      pg_d   = pg_in;
    end else if (commit) begin
      busy_d = 1'b0;
      op_d   = OP_IDLE;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_IDLE;
      pg_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      pg_q   <= pg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '1;
    end else if (commit) begin
      if (op_q == OP_ERASE) begin
        for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '1;
      end else if (op_q == OP_PROG) begin
        for (int w = 0; w < PAGE_WORDS; w++)
          mem[{pg_q, w[WIDX_W-1:0]}] <= page_buf[w];
      end
    end
  end

  assign rd_data = mem[rd_addr];
  assign busy    = busy_q;

  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);
  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(mem[0]) && $stable(mem[MEM_WORDS-1])));
  p_erase_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op_q == OP_ERASE) |=> (mem[0] == 16'hFFFF && mem[MEM_WORDS-1] == 16'hFFFF));
  p_bad_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && !busy_q && !cmd_ok) |=> !busy_q);
  p_wr_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0 && wr_ev) |=> (busy_q && $stable(op_q) && $stable(pg_q)));

endmodule

// File: rtl/pflash_prog_if.sv
module pflash_prog_if
  import pflash_pkg::*;
#(
  parameter int PAGE_WORDS = 128,
  parameter int PAGES      = 8,
  parameter int BUSY_CYC   = 16,
  localparam int WIDX_W    = $clog2(PAGE_WORDS),
  localparam int PG_W      = $clog2(PAGES),
  localparam int MEM_AW    = WIDX_W + PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              byte_hi,
  input  logic [7:0]        data_in,
  input  logic              load_stb,
  input  logic              latch_stb,
  input  logic              wr_n,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              rdy
);

  logic [1:0]      rst_ff;
  logic            rst_sync_n;
  logic [2:0]      pins;
  logic [2:0]      ev;
  logic            busy;
  logic [7:0]      cmd_q;
  logic [PG_W-1:0] pg;
  logic [15:0]     page_buf [PAGE_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  assign pins = {wr_n, latch_stb, load_stb};

  generate
    for (genvar gi = 0; gi < 3; gi++) begin : g_strobe
      pflash_edge_det #(
        .IDLE_LVL (gi == 2),
        .RISING   (gi != 2)
      ) u_det (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .pin   (pins[gi]),
        .pulse (ev[gi])
      );
    end
  endgenerate

  pflash_load_regs #(
    .PAGE_WORDS (PAGE_WORDS),
    .PAGES      (PAGES)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .busy     (busy),
    .load_ev  (ev[0]),
    .latch_ev (ev[1]),
    .sel      (mode_sel),
    .byte_hi  (byte_hi),
    .din      (data_in),
    .cmd_q    (cmd_q),
    .pg_o     (pg),
    .page_buf (page_buf)
  );

  pflash_array #(
    .PAGE_WORDS (PAGE_WORDS),
    .PAGES      (PAGES),
    .BUSY_CYC   (BUSY_CYC)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_ev    (ev[2]),
    .cmd      (cmd_q),
    .pg_in    (pg),
    .page_buf (page_buf),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .busy     (busy)
  );

  assign rdy = ~busy;

endmodule

// File: tb/pflash_prog_if_tb.sv
`timescale 1ns/1ps
module pflash_prog_if_tb_top;

  localparam int PW = 128;
  localparam int NP = 8;
  localparam int BC = 24;
  localparam int MW = PW * NP;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic        byte_hi;
  logic [7:0]  data_in;
  logic        load_stb;
  logic        latch_stb;
  logic        wr_n;
  logic [9:0]  rd_addr;
  logic [15:0] rd_data;
  logic        rdy;

  always #2 clk = ~clk;

  pflash_prog_if #(.PAGE_WORDS(PW), .PAGES(NP), .BUSY_CYC(BC)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .byte_hi(byte_hi),
    .data_in(data_in), .load_stb(load_stb), .latch_stb(latch_stb),
    .wr_n(wr_n), .rd_addr(rd_addr), .rd_data(rd_data), .rdy(rdy)
  );

  logic [15:0] m_mem [MW];
  logic [15:0] m_buf [PW];
  logic [7:0]  m_cmd, m_alo, m_ahi, m_dlo, m_dhi;
  bit          frozen;
  int          n_chk, n_fail;
  bit          done;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [1:0] m, input bit b, input logic [7:0] v);
    mode_sel = m; byte_hi = b; data_in = v;
    tick(1); load_stb = 1'b1;
    tick(3); load_stb = 1'b0;
    tick(3);
    if (!frozen) begin
      case (m)
        2'b10: m_cmd = v;
        2'b00: if (b) m_ahi = v; else m_alo = v;
        2'b01: if (b) m_dhi = v; else m_dlo = v;
        default: ;
      endcase
    end
  endtask

  task automatic do_latch();
    tick(1); latch_stb = 1'b1;
    tick(3); latch_stb = 1'b0;
    tick(3);
    if (!frozen) m_buf[m_alo % PW] = {m_dhi, m_dlo};
  endtask

  function automatic int exp_page();
    return ((int'(m_ahi) * 256 + int'(m_alo)) / PW) % NP;
  endfunction

  task automatic do_write(output int lowc);
    lowc = 0;
    wr_n = 1'b0;
    for (int i = 0; i < BC + 12; i++) begin
      tick(1);
      if (i == 2) wr_n = 1'b1;
      if (!rdy) lowc++;
    end
  endtask

  task automatic apply_op();
    if (m_cmd == 8'h80) begin
      for (int i = 0; i < MW; i++) m_mem[i] = 16'hFFFF;
    end else if (m_cmd == 8'h10) begin
      for (int w = 0; w < PW; w++) m_mem[exp_page() * PW + w] = m_buf[w];
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < MW; i++) begin
      rd_addr = 10'(i);
      #0.5;
      if (rd_data !== m_mem[i] && bad < 4) begin
        bad++;
        $display("  word %0d", i);
      end
      chk(rd_data === m_mem[i], req, int'(rd_data), int'(m_mem[i]));
    end
  endtask

  task automatic fill_words(input int k);
    for (int j = 0; j < k; j++) begin
      logic [7:0] lo;
      lo = 8'($urandom);
      if (j == 0) lo = {m_alo[7], 7'h00};
      if (j == 1) lo = {m_alo[7], 7'h7F};
      do_load(2'b00, 1'b0, lo);
      do_load(2'b01, 1'b0, 8'($urandom));
      do_load(2'b01, 1'b1, 8'($urandom));
      do_latch();
    end
  endtask

  task automatic prog_and_check(input string req);
    int lc;
    do_write(lc);
    chk(lc == BC, "R8 busy width", lc, BC);
    apply_op();
    cmp_mem(req);
  endtask

  initial begin
    int lc;
    void'($urandom(32'd4242));
    rst_n = 1'b0; mode_sel = 2'b11; byte_hi = 1'b0; data_in = '0;
    load_stb = 1'b0; latch_stb = 1'b0; wr_n = 1'b1; rd_addr = '0;
    frozen = 1'b0; m_cmd = '0; m_alo = '0; m_ahi = '0; m_dlo = '0; m_dhi = '0;
    for (int i = 0; i < MW; i++) m_mem[i] = 16'hFFFF;
    for (int w = 0; w < PW; w++) m_buf[w] = 16'hFFFF;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R11: reset state
    chk(rdy == 1'b1, "R11 ready after reset", int'(rdy), 1);
    cmp_mem("R11 erased after reset");

    // R1, R2, R3, R5, R6: random page programs
    do_load(2'b10, 1'b0, 8'h10);
    for (int rep = 0; rep < 4; rep++) begin
      fill_words(6);
      do_load(2'b00, 1'b1, 8'($urandom));
      prog_and_check("R1/R2/R3/R5/R6 page program");
    end

    // R2, R6: page bit from low address byte bit 7
    do_load(2'b00, 1'b1, 8'h00);
    do_load(2'b00, 1'b0, 8'h80);
    fill_words(3);
    do_load(2'b00, 1'b0, 8'h85);
    chk(exp_page() == 1, "R2 page model", exp_page(), 1);
    prog_and_check("R2/R6 low byte page bit");

    // R4: mode 11 strobe leaves command and address alone
    do_load(2'b11, 1'b0, 8'h80);
    do_load(2'b11, 1'b1, 8'hFF);
    prog_and_check("R4 mode 11 ignored");

    // R10: unknown command
    do_load(2'b10, 1'b0, 8'h55);
    do_write(lc);
    chk(lc == 0, "R10 no busy on unknown command", lc, 0);
    cmp_mem("R10 array unchanged");

    // R9: strobes while busy
    do_load(2'b10, 1'b0, 8'h10);
    do_load(2'b00, 1'b1, 8'h03);
    fill_words(2);
    fork
      do_write(lc);
      begin
        tick(3);
        frozen = 1'b1;
        do_load(2'b10, 1'b0, 8'h80);
        do_load(2'b00, 1'b0, 8'h12);
        do_load(2'b01, 1'b0, 8'hA5);
        frozen = 1'b0;
      end
    join
    chk(lc == BC, "R8 busy width", lc, BC);
    apply_op();
    cmp_mem("R9 program during busy strobes");
    fork
      do_write(lc);
      begin
        tick(3);
        frozen = 1'b1;
        do_load(2'b01, 1'b1, 8'h5A);
        do_latch();
        frozen = 1'b0;
      end
    join
    chk(lc == BC, "R8 busy width", lc, BC);
    apply_op();
    cmp_mem("R9 state kept after busy strobes");

    // R7, R1: chip erase
    do_load(2'b10, 1'b0, 8'h80);
    prog_and_check("R7 chip erase");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule